// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block records the value of an external free-running counter at the moment a chosen transition appears on one of its capture pins. It has three capture channels by default. A parameter adds a fourth. Each channel has its own edge-select field, its own interrupt enable and its own sticky event flag. Software programs the channels through a plain write-enable/address/data port, and it clears flags by writing a one to each flag it wants to clear.

Capture pins are asynchronous. Each pin first passes through a two-flop synchroniser. A registered copy of the synchronised level then yields rising and falling strobes. When the strobe selected by the channel's edge field fires, the current counter value is stored in the channel's capture register and the channel's flag is set. A single interrupt line combines every flag whose enable bit is set.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every capture register holds 0, every flag is clear and `irq_o` is low.
- R2: The edge field of channel k sits at bits [2k+1:2k] of a configuration write (`wr_addr_i` = 0). The value 1 captures on rising edges only, 2 on falling edges only and 3 on both.
- R3: An edge field of 0 disables the channel: pin transitions change neither its capture register nor its flag.
- R4: A pin change applied during the cycle before rising clock edge E0 is stored at edge E0+2. The stored value is the `count_i` value present at that edge (three clocks from the pin).
- R5: A capture sets the channel's flag, and the flag stays set until software clears it.
- R6: A write to `wr_addr_i` = 1 clears exactly the flags whose bits in `wr_data_i[N-1:0]` are 1. All other flags are left unchanged.
- R7: When a clear and a new capture reach the same channel in the same cycle, the capture wins and the flag stays set.
- R8: The interrupt enable of channel k is configuration bit 2N+k, where N is the number of channels. `irq_o` is high exactly when some flag is set and its enable bit is set.
- R9: Setting parameter `EXTRA_CH` to 1 adds a fourth channel that behaves like the others.
- R10: Each new capture overwrites the previous capture value of that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| count_i | input | CNT_W | Free-running counter value to capture |
| cap_pin_i | input | N | Asynchronous capture pins, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = configuration, 1 = flag clear |
| wr_data_i | input | 3N | Write data |
| cap_val_o | output | N*CNT_W | Capture registers, channel k at bits [k*CNT_W +: CNT_W] |
| flags_o | output | N | Sticky capture flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle by the assertions:
- a capture strobe stores the counter value seen in that cycle;
- a clear without a strobe drops the flag, while a clear that meets a strobe leaves it set;
- a flag holds unless it is cleared;
- a disabled channel never moves its capture register;
- configuration changes only when it is written;
- the interrupt is never raised without a flag.

Other behaviour can only be shown by the bench's scenarios:
- the end-to-end three-clock pin-to-capture latency;
- whether each edge encoding picks the right transition;
- the exact bit mapping of the clear mask and the enables;
- the fourth channel added by the parameter.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_RISE = 2'd1,
    SEL_FALL = 2'd2,
    SEL_BOTH = 2'd3
  } edge_sel_e;

  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_CLR = 1'b1;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R4: a strobe appears only after the synchronised level has moved
  p_rise_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> prev_q);
  p_fall_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !prev_q);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_sel_e        sel_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);
  logic             evt;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_comb begin
    unique case (sel_i)
      SEL_RISE: evt = rise_i;
      SEL_FALL: evt = fall_i;
      SEL_BOTH: evt = rise_i | fall_i;
      default:  evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (evt) cap_q <= count_i;
      // new event has priority over a software clear
      if (evt)        flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  p_capture_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> cap_o == $past(count_i));
  p_off_no_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_OFF) |=> $stable(cap_o));
  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  p_flag_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt) |=> !flag_o);
  p_event_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt) |=> flag_o);
endmodule

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import cap_pkg::*;
#(
  parameter int NCH = 3,
  localparam int DATA_W = 3 * NCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [2*NCH-1:0]  sel_o,
  output logic [NCH-1:0]    ie_o,
  output logic [NCH-1:0]    clr_o
);
  logic [2*NCH-1:0] sel_q;
  logic [NCH-1:0]   ie_q;
  logic             cfg_we;

  assign cfg_we = wr_en_i && (wr_addr_i == ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ie_q  <= '0;
    end else if (cfg_we) begin
      sel_q <= wr_data_i[2*NCH-1:0];
      ie_q  <= wr_data_i[2*NCH +: NCH];
    end
  end

  assign sel_o = sel_q;
  assign ie_o  = ie_q;
  assign clr_o = (wr_en_i && (wr_addr_i == ADDR_CLR)) ? wr_data_i[NCH-1:0] : '0;

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_CFG) |=> ($stable(sel_o) && $stable(ie_o)));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int EXTRA_CH = 0,
  localparam int NCH     = 3 + EXTRA_CH,
  localparam int DATA_W  = 3 * NCH
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     count_i,
  input  logic [NCH-1:0]       cap_pin_i,
  input  logic                 wr_en_i,
  input  logic                 wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [NCH*CNT_W-1:0] cap_val_o,
  output logic [NCH-1:0]       flags_o,
  output logic                 irq_o
);
  logic [2*NCH-1:0] sel;
  logic [NCH-1:0]   ie;
  logic [NCH-1:0]   clr;
  logic [NCH-1:0]   rise;
  logic [NCH-1:0]   fall;

  cap_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel),
    .ie_o      (ie),
    .clr_o     (clr)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (cap_pin_i[k]),
      .rise_o (rise[k]),
      .fall_o (fall[k])
    );

    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (edge_sel_e'(sel[2*k +: 2])),
      .rise_i  (rise[k]),
      .fall_i  (fall[k]),
      .count_i (count_i),
      .clr_i   (clr[k]),
      .cap_o   (cap_val_o[k*CNT_W +: CNT_W]),
      .flag_o  (flags_o[k])
    );
  end

  assign irq_o = |(flags_o & ie);

  p_irq_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o != '0));
  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (flags_o == '0 && !irq_o));
endmodule

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  localparam int CW = 16;
  localparam int N  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic [N-1:0]  pins = '0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [3*N-1:0] wr_data = '0;
  logic [N*CW-1:0] cap_val;
  logic [N-1:0]  flags;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;

  logic [1:0]    tb_sel [N];
  logic          tb_lvl [N];
  logic [CW-1:0] exp_q [N][$];
  logic [CW-1:0] prev_v [N];
  logic [CW-1:0] snap;

  always #4 clk = ~clk;

  edge_capture_unit #(.CNT_W(CW), .EXTRA_CH(1)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .count_i   (cnt),
    .cap_pin_i (pins),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .cap_val_o (cap_val),
    .flags_o   (flags),
    .irq_o     (irq)
  );

  initial forever begin
    @(negedge clk);
    cnt = cnt + 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cv(input int k);
    return cap_val[k*CW +: CW];
  endfunction

  // scoreboard monitor: every change of a capture register is popped and compared
  initial begin
    for (int k = 0; k < N; k++) prev_v[k] = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        for (int k = 0; k < N; k++) begin
          if (cv(k) != prev_v[k]) begin
            if (exp_q[k].size() == 0)
              chk(1'b0, $sformatf("R3 unexpected capture ch%0d", k), cv(k), prev_v[k]);
            else begin
              logic [CW-1:0] e;
              e = exp_q[k].pop_front();
              chk(cv(k) == e, $sformatf("R4 capture value ch%0d", k), cv(k), e);
            end
            prev_v[k] = cv(k);
          end
        end
      end
    end
  end

  task automatic reg_write(input logic a, input logic [3*N-1:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] s0, s1, s2, s3, input logic [N-1:0] ie);
    tb_sel[0] = s0; tb_sel[1] = s1; tb_sel[2] = s2; tb_sel[3] = s3;
    reg_write(1'b0, {ie, s3, s2, s1, s0});
  endtask

  // drive one pin level; expected value pushed when the selected edge occurs
  task automatic drive_pin(input int k, input logic v);
    logic r, f;
    @(posedge clk); #2;
    r = !tb_lvl[k] && v;
    f = tb_lvl[k] && !v;
    if ((r && tb_sel[k][0]) || (f && tb_sel[k][1]))
      exp_q[k].push_back(cnt + CW'(3));
    pins[k] = v;
    tb_lvl[k] = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin tb_sel[k] = 2'd0; tb_lvl[k] = 1'b0; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cap_val == '0, "R1 capture regs at reset", int'(cap_val[CW-1:0]), 0);
    chk(flags == '0, "R1 flags at reset", flags, 0);
    chk(irq == 1'b0, "R1 irq at reset", irq, 0);

    // R2: ch0 rise, ch1 fall, ch2 both, ch3 off, no enables
    cfg(2'd1, 2'd2, 2'd3, 2'd0, 4'b0000);
    for (int k = 0; k < N; k++) drive_pin(k, 1'b1);
    @(negedge clk);
    snap = cv(0);
    chk(flags == 4'b0101, "R2 flags after rising edges", flags, 4'b0101);
    chk(cv(1) == '0, "R2 falling-only channel ignored rise", cv(1), 0);
    for (int k = 0; k < N; k++) drive_pin(k, 1'b0);
    @(negedge clk);
    chk(cv(0) == snap, "R2 rising-only channel ignored fall", cv(0), snap);
    chk(flags == 4'b0111, "R5 flags sticky after falling edges", flags, 4'b0111);
    chk(cv(3) == '0, "R3 disabled channel register", cv(3), 0);
    chk(flags[3] == 1'b0, "R3 disabled channel flag", flags[3], 0);
    chk(irq == 1'b0, "R8 irq low with no enables", irq, 0);

    // R8 enable ch1 only
    cfg(2'd1, 2'd2, 2'd3, 2'd0, 4'b0010);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq with ch1 flag enabled", irq, 1);

    // R6 clear ch1 only
    reg_write(1'b1, 12'h002);
    @(negedge clk);
    chk(flags == 4'b0101, "R6 only masked flag cleared", flags, 4'b0101);
    chk(irq == 1'b0, "R8 irq low after enabled flag cleared", irq, 0);
    reg_write(1'b1, 12'h005);
    @(negedge clk);
    chk(flags == 4'b0000, "R6 mask clears two flags", flags, 0);

    // R7 same-cycle clear and capture on ch0, clear of ch2 also in that write
    drive_pin(2, 1'b1);
    @(posedge clk); #2;
    exp_q[0].push_back(cnt + CW'(3));
    pins[0] = 1'b1; tb_lvl[0] = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 12'h005;
    @(posedge clk); #2;
    wr_en = 1'b0;
    @(negedge clk);
    chk(flags[0] == 1'b1, "R7 capture wins over clear", flags[0], 1);
    chk(flags[2] == 1'b0, "R6 other channel cleared in same write", flags[2], 0);
    drive_pin(0, 1'b0);

    // R10 repeated captures on both-edge channel
    for (int i = 0; i < 4; i++) drive_pin(2, ~tb_lvl[2]);
    @(negedge clk);
    chk(exp_q[2].size() == 0, "R10 all overwrites observed", exp_q[2].size(), 0);

    // R9 fourth channel
    cfg(2'd1, 2'd2, 2'd3, 2'd3, 4'b1000);
    reg_write(1'b1, 12'h00F);
    drive_pin(3, 1'b1);
    drive_pin(3, 1'b0);
    @(negedge clk);
    chk(flags == 4'b1000, "R9 fourth channel flag", flags, 4'b1000);
    chk(irq == 1'b1, "R9 fourth channel interrupt", irq, 1);

    // R3 switch ch2 off: toggles leave register and flag untouched
    cfg(2'd1, 2'd2, 2'd0, 2'd3, 4'b1000);
    @(negedge clk);
    snap = cv(2);
    drive_pin(2, ~tb_lvl[2]);
    drive_pin(2, ~tb_lvl[2]);
    @(negedge clk);
    chk(cv(2) == snap, "R3 off channel register unchanged", cv(2), snap);
    chk(flags[2] == 1'b0, "R3 off channel flag unchanged", flags[2], 0);

    repeat (6) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++)
      chk(exp_q[k].size() == 0, $sformatf("R4 pending captures ch%0d", k), exp_q[k].size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule